// File: doc/BRIEF.md
# Multicycle RISC Instruction Sequencer

This block is the control and datapath sequencer of a small non-pipelined 32-bit RISC core. Every instruction passes through a fetch phase and a decode phase. After that it takes only the execute, memory-access and register-update phases its class needs. The time an instruction occupies therefore depends on what it is. Internally the block holds the program counter, the instruction word, the sequential next address, two operand latches, a sign-extended immediate, the ALU result, the loaded data word and a branch-condition flag. It also holds a 32-entry register file whose entry zero always reads as zero.

The block has one memory port, shared by instruction fetches and data accesses. The memory must return read data in the same cycle as the request. The block marks each read that is an instruction fetch.

Instructions use the common three-format 32-bit layout:
- opcode in [31:26]
- first source register in [25:21]
- second source or I-format destination in [20:16]
- R-format destination in [15:11]
- shift amount in [10:6]
- function code in [5:0]
- 16-bit immediate in [15:0]
- 26-bit jump target in [25:0]

Top module: `mc_sequencer`

## Requirements
- R1: While reset is low, no memory write is issued. The first clock cycle after reset is released is an instruction fetch from address 0.
- R2: A fetch reads memory at PC with `mem_fetch` high. Unless the instruction redirects control, the next fetch is at PC+4. PC does not change between a fetch and the last phase of that instruction.
- R3: R-format instructions (opcode 0x00) compute from the two source registers and write the result to the [15:11] register. Each takes 4 cycles from its fetch to the next fetch. The function codes are: add 0x20, subtract 0x22, and 0x24, or 0x25, xor 0x26, nor 0x27, signed set-less-than 0x2A, and shifts of the [20:16] register by [10:6]. The shifts are left 0x00, logical right 0x02 and arithmetic right 0x03.
- R4: Immediate ALU instructions take the first source register and the sign-extended immediate, and write the result to the [20:16] register. Each takes 4 cycles. The opcodes are: add 0x08, set-less-than 0x0A, and 0x0C, or 0x0D, xor 0x0E.
- R5: Load word (opcode 0x23) reads memory at rs plus the sign-extended immediate and writes the word to the [20:16] register. It takes 5 cycles.
- R6: Store word (opcode 0x2B) writes the [20:16] register to memory at rs plus the sign-extended immediate. The write happens in the fourth cycle after the fetch, and the instruction takes 4 cycles.
- R7: Branch-if-equal (opcode 0x04) goes to PC+4 plus the sign-extended immediate, taken as a byte offset, when the two source registers are equal. Otherwise it goes to PC+4. It takes 4 cycles.
- R8: Branch-if-negative (opcode 0x01 with [20:16] equal to zero) takes the same target when the first source register is negative, and takes 4 cycles.
- R9: Jump (opcode 0x02) goes to {(PC+4)[31:28], target, 2'b00} and takes 3 cycles.
- R10: Jump-and-link-register (opcode 0x00, function 0x09) goes to the address held in the first source register, writes PC+8 into register 31, and takes 3 cycles.
- R11: Register 0 reads as zero whatever is written to it.
- R12: Any other encoding writes nothing, takes 2 cycles, and continues at PC+4.
- R13: A read and a write are never requested in the same cycle, and writes occur only in the memory phase of a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_fetch | output | 1 | The current read is an instruction fetch |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the cycle of the request |

## Verification
A wrong phase or a wrong instruction class shows up at the next fetch. Either the fetch moves by a cycle or it lands at the wrong address, so the fault is visible within five cycles of the faulty fetch. A wrong operand, immediate, ALU result or register-file update is only visible when a later store exposes that register on `mem_wdata`. For that reason every computed value is stored soon after it is produced. A store is also checked for the exact cycle of its write relative to its own fetch.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int REG_N      = 32;
    localparam int REG_AW     = $clog2(REG_N);
    localparam int SH_W       = $clog2(WORD_W);

    localparam logic [5:0] OPC_RFMT  = 6'h00;
    localparam logic [5:0] OPC_BNEG  = 6'h01;
    localparam logic [5:0] OPC_JMP   = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_SLTI  = 6'h0A;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_XORI  = 6'h0E;
    localparam logic [5:0] OPC_LDW   = 6'h23;
    localparam logic [5:0] OPC_STW   = 6'h2B;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_JLR  = 6'h09;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2A;

    typedef enum logic [2:0] {
        PH_IF  = 3'd0,
        PH_ID  = 3'd1,
        PH_EX  = 3'd2,
        PH_MEM = 3'd3,
        PH_WB  = 3'd4
    } phase_e;

    typedef enum logic [3:0] {
        CL_NOP, CL_ALUR, CL_ALUI, CL_LOAD, CL_STORE,
        CL_BEQ, CL_BNEG, CL_JUMP, CL_JLINK
    } iclass_e;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
        OP_NOR, OP_SLT, OP_SLL, OP_SRL, OP_SRA
    } aluop_e;

    typedef struct packed {
        phase_e              ph;
        logic [WORD_W-1:0]   pc;
        logic [WORD_W-1:0]   npc;
        logic [WORD_W-1:0]   ir;
        logic [WORD_W-1:0]   opa;
        logic [WORD_W-1:0]   opb;
        logic [WORD_W-1:0]   imm;
        logic [WORD_W-1:0]   res;
        logic [WORD_W-1:0]   ldata;
        logic                cond;
    } seq_regs_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] rt_fld,
    input  logic [5:0] funct,
    output iclass_e    cls,
    output aluop_e     op
);
    always_comb begin
        cls = CL_NOP;
        op  = OP_ADD;
        unique case (opcode)
            OPC_RFMT: begin
                cls = CL_ALUR;
                unique case (funct)
                    FN_ADD:  op = OP_ADD;
                    FN_SUB:  op = OP_SUB;
                    FN_AND:  op = OP_AND;
                    FN_OR:   op = OP_OR;
                    FN_XOR:  op = OP_XOR;
                    FN_NOR:  op = OP_NOR;
                    FN_SLT:  op = OP_SLT;
                    FN_SLL:  op = OP_SLL;
                    FN_SRL:  op = OP_SRL;
                    FN_SRA:  op = OP_SRA;
                    FN_JLR:  cls = CL_JLINK;
                    default: cls = CL_NOP;
                endcase
            end
            OPC_ADDI: begin cls = CL_ALUI; op = OP_ADD; end
            OPC_SLTI: begin cls = CL_ALUI; op = OP_SLT; end
            OPC_ANDI: begin cls = CL_ALUI; op = OP_AND; end
            OPC_ORI:  begin cls = CL_ALUI; op = OP_OR;  end
            OPC_XORI: begin cls = CL_ALUI; op = OP_XOR; end
            OPC_LDW:  cls = CL_LOAD;
            OPC_STW:  cls = CL_STORE;
            OPC_BEQ:  cls = CL_BEQ;
            OPC_BNEG: cls = (rt_fld == 5'd0) ? CL_BNEG : CL_NOP;
            OPC_JMP:  cls = CL_JUMP;
            default:  cls = CL_NOP;
        endcase
    end
endmodule

// File: rtl/seq_alu.sv
module seq_alu
    import seq_pkg::*;
#(
    parameter int W = WORD_W,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [SW-1:0] shamt,
    input  aluop_e        op,
    output logic [W-1:0]  y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            OP_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            OP_SLL:  y = b << shamt;
            OP_SRL:  y = b >> shamt;
            OP_SRA:  y = $unsigned($signed(b) >>> shamt);
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile
    import seq_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = REG_N,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
    import seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_PC = '0,
    parameter int                LINK_IDX = REG_N - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_fetch,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam logic [WORD_W-1:0] STEP     = WORD_W'(WORD_BYTES);
    localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(LINK_IDX);

    seq_regs_t s_q, s_d;

    iclass_e           dec_cls;
    aluop_e            dec_op;
    logic [WORD_W-1:0] rf_a, rf_b, alu_b, alu_y, br_tgt;
    logic              rf_we;
    logic [REG_AW-1:0] rf_wa;
    logic [WORD_W-1:0] rf_wd;

    seq_decode u_dec (
        .opcode (s_q.ir[31:26]),
        .rt_fld (s_q.ir[20:16]),
        .funct  (s_q.ir[5:0]),
        .cls    (dec_cls),
        .op     (dec_op)
    );

    seq_regfile #(.W(WORD_W), .N(REG_N)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (s_q.ir[25:21]),
        .ra_b  (s_q.ir[20:16]),
        .rd_a  (rf_a),
        .rd_b  (rf_b),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    assign alu_b  = (dec_cls == CL_ALUR) ? s_q.opb : s_q.imm;
    assign br_tgt = s_q.npc + s_q.imm;

    seq_alu #(.W(WORD_W)) u_alu (
        .a     (s_q.opa),
        .b     (alu_b),
        .shamt (s_q.ir[10:6]),
        .op    (dec_op),
        .y     (alu_y)
    );

    always_comb begin
        s_d       = s_q;
        rf_we     = 1'b0;
        rf_wa     = '0;
        rf_wd     = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_fetch = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (s_q.ph)
            PH_IF: begin
                mem_rd    = 1'b1;
                mem_fetch = 1'b1;
                mem_addr  = s_q.pc;
                s_d.ir    = mem_rdata;
                s_d.npc   = s_q.pc + STEP;
                s_d.ph    = PH_ID;
            end
            PH_ID: begin
                s_d.opa = rf_a;
                s_d.opb = rf_b;
                s_d.imm = {{(WORD_W-16){s_q.ir[15]}}, s_q.ir[15:0]};
                if (dec_cls == CL_NOP) begin
                    s_d.pc = s_q.npc;
                    s_d.ph = PH_IF;
                end else begin
                    s_d.ph = PH_EX;
                end
            end
            PH_EX: begin
                unique case (dec_cls)
                    CL_ALUR, CL_ALUI: begin
                        s_d.res = alu_y;
                        s_d.ph  = PH_WB;
                    end
                    CL_LOAD, CL_STORE: begin
                        s_d.res = alu_y;
                        s_d.ph  = PH_MEM;
                    end
                    CL_BEQ: begin
                        s_d.res  = br_tgt;
                        s_d.cond = (s_q.opa == s_q.opb);
                        s_d.ph   = PH_WB;
                    end
                    CL_BNEG: begin
                        s_d.res  = br_tgt;
                        s_d.cond = s_q.opa[WORD_W-1];
                        s_d.ph   = PH_WB;
                    end
                    CL_JUMP: begin
                        s_d.pc = {s_q.npc[WORD_W-1:28], s_q.ir[25:0], 2'b00};
                        s_d.ph = PH_IF;
                    end
                    CL_JLINK: begin
                        rf_we  = 1'b1;
                        rf_wa  = LINK_REG;
                        rf_wd  = s_q.npc + STEP;
                        s_d.pc = s_q.opa;
                        s_d.ph = PH_IF;
                    end
                    default: begin
                        s_d.pc = s_q.npc;
                        s_d.ph = PH_IF;
                    end
                endcase
            end
            PH_MEM: begin
                mem_addr = s_q.res;
                if (dec_cls == CL_STORE) begin
                    mem_wr    = 1'b1;
                    mem_wdata = s_q.opb;
                    s_d.pc    = s_q.npc;
                    s_d.ph    = PH_IF;
                end else begin
                    mem_rd    = 1'b1;
                    s_d.ldata = mem_rdata;
                    s_d.ph    = PH_WB;
                end
            end
            PH_WB: begin
                s_d.pc = s_q.npc;
                s_d.ph = PH_IF;
                unique case (dec_cls)
                    CL_ALUR: begin
                        rf_we = 1'b1;
                        rf_wa = s_q.ir[15:11];
                        rf_wd = s_q.res;
                    end
                    CL_ALUI: begin
                        rf_we = 1'b1;
                        rf_wa = s_q.ir[20:16];
                        rf_wd = s_q.res;
                    end
                    CL_LOAD: begin
                        rf_we = 1'b1;
                        rf_wa = s_q.ir[20:16];
                        rf_wd = s_q.ldata;
                    end
                    CL_BEQ, CL_BNEG: begin
                        if (s_q.cond) s_d.pc = s_q.res;
                    end
                    default: ;
                endcase
            end
            default: s_d.ph = PH_IF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.pc <= RESET_PC;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/seq_checker.sv
module seq_checker
    import seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input phase_e            ph,
    input iclass_e           cls,
    input logic [WORD_W-1:0] pc_q,
    input logic [WORD_W-1:0] npc_q,
    input logic              mem_rd,
    input logic              mem_wr
);
    AST_NEXT_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IF) |=> (npc_q == $past(pc_q) + WORD_W'(WORD_BYTES))); // R2

    AST_PC_HELD_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IF) |=> $stable(pc_q)); // R2

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R13

    AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (ph == PH_MEM && cls == CL_STORE)); // R6

    AST_LOAD_WB_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_WB && cls == CL_LOAD) |-> ($past(ph) == PH_MEM)); // R5

    AST_JUMP_ENDS_IN_EX: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_EX && (cls == CL_JUMP || cls == CL_JLINK)) |=> (ph == PH_IF)); // R9

    AST_UNKNOWN_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_ID && cls == CL_NOP) |=> (ph == PH_IF && pc_q == $past(npc_q))); // R12
endmodule

bind mc_sequencer seq_checker u_seq_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph     (s_q.ph),
    .cls    (dec_cls),
    .pc_q   (s_q.pc),
    .npc_q  (s_q.npc),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr)
);

// File: tb/mc_sequencer_bench.sv
`timescale 1ns/1ps
module mc_sequencer_bench;
    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] instr;
        logic [3:0]  cyc;
        logic [31:0] nxt;
        logic        wr;
        logic [31:0] waddr;
        logic [31:0] wdata;
        logic [23:0] tag;
    } row_t;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int op, int tgt);
        return {6'(op), 26'(tgt)};
    endfunction
    function automatic row_t mk(int a, logic [31:0] ins, int c, int n,
                                bit w, logic [31:0] wa, logic [31:0] wd, logic [23:0] t);
        row_t r;
        r.addr = 32'(a); r.instr = ins; r.cyc = 4'(c); r.nxt = 32'(n);
        r.wr = w; r.waddr = wa; r.wdata = wd; r.tag = t;
        return r;
    endfunction

    localparam int NROW = 36;
    localparam int NWR  = 13;
    localparam row_t PROG [NROW] = '{
        mk(  0, enc_i(8, 0, 1, 5),          4,   4, 0, 0, 0, "R4"),
        mk(  4, enc_i(8, 0, 2, -3),         4,   8, 0, 0, 0, "R4"),
        mk(  8, enc_r(1, 2, 3, 0, 'h20),    4,  12, 0, 0, 0, "R3"),
        mk( 12, enc_r(1, 2, 4, 0, 'h22),    4,  16, 0, 0, 0, "R3"),
        mk( 16, enc_r(2, 1, 5, 0, 'h2A),    4,  20, 0, 0, 0, "R3"),
        mk( 20, enc_r(0, 0, 6, 0, 'h27),    4,  24, 0, 0, 0, "R3"),
        mk( 24, enc_r(0, 1, 7, 4, 'h00),    4,  28, 0, 0, 0, "R3"),
        mk( 28, enc_r(0, 2, 8, 1, 'h03),    4,  32, 0, 0, 0, "R3"),
        mk( 32, enc_i('h0C, 2, 9, 'hF0),    4,  36, 0, 0, 0, "R4"),
        mk( 36, enc_i('h0D, 0, 10, 'h8000), 4,  40, 0, 0, 0, "R4"),
        mk( 40, enc_i('h2B, 0, 3, 'h100),   4,  44, 1, 32'h100, 32'h2,        "R3"),
        mk( 44, enc_i('h2B, 0, 4, 'h104),   4,  48, 1, 32'h104, 32'h8,        "R3"),
        mk( 48, enc_i('h2B, 0, 5, 'h108),   4,  52, 1, 32'h108, 32'h1,        "R3"),
        mk( 52, enc_i('h2B, 0, 6, 'h10C),   4,  56, 1, 32'h10C, 32'hFFFFFFFF, "R3"),
        mk( 56, enc_i('h2B, 0, 7, 'h110),   4,  60, 1, 32'h110, 32'h50,       "R3"),
        mk( 60, enc_i('h2B, 0, 8, 'h114),   4,  64, 1, 32'h114, 32'hFFFFFFFE, "R3"),
        mk( 64, enc_i('h2B, 0, 9, 'h118),   4,  68, 1, 32'h118, 32'hF0,       "R4"),
        mk( 68, enc_i('h2B, 0, 10, 'h11C),  4,  72, 1, 32'h11C, 32'hFFFF8000, "R4"),
        mk( 72, enc_i('h23, 0, 11, 'h200),  5,  76, 0, 0, 0, "R5"),
        mk( 76, enc_i('h2B, 0, 11, 'h120),  4,  80, 1, 32'h120, 32'hCAFEF00D, "R5"),
        mk( 80, enc_r(1, 1, 0, 0, 'h20),    4,  84, 0, 0, 0, "R11"),
        mk( 84, enc_i('h2B, 0, 0, 'h124),   4,  88, 1, 32'h124, 32'h0,        "R11"),
        mk( 88, 32'hFC000000,               2,  92, 0, 0, 0, "R12"),
        mk( 92, enc_i(4, 1, 2, 100),        4,  96, 0, 0, 0, "R7"),
        mk( 96, enc_i(4, 1, 1, 8),          4, 108, 0, 0, 0, "R7"),
        mk(108, enc_i(1, 1, 0, 8),          4, 112, 0, 0, 0, "R8"),
        mk(112, enc_i(1, 2, 0, 12),         4, 128, 0, 0, 0, "R8"),
        mk(128, enc_j(2, 36),               3, 144, 0, 0, 0, "R9"),
        mk(144, enc_i(8, 0, 12, 200),       4, 148, 0, 0, 0, "R4"),
        mk(148, enc_r(12, 0, 31, 0, 'h09),  3, 200, 0, 0, 0, "R10"),
        mk(200, enc_i('h2B, 0, 31, 'h128),  4, 204, 1, 32'h128, 32'd156,      "R10"),
        mk(204, enc_i(8, 0, 14, 'h204),     4, 208, 0, 0, 0, "R4"),
        mk(208, enc_i('h23, 14, 13, -4),    5, 212, 0, 0, 0, "R5"),
        mk(212, enc_i('h2B, 0, 13, 'h12C),  4, 216, 1, 32'h12C, 32'hCAFEF00D, "R5"),
        mk(216, enc_i('h2B, 14, 1, -4),     4, 220, 1, 32'h200, 32'h5,        "R6"),
        mk(220, enc_j(2, 55),               3, 220, 0, 0, 0, "R9")
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd, mem_wr, mem_fetch;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] mem [256];

    always #2 clk = ~clk;

    mc_sequencer u_mc_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_fetch (mem_fetch),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;

    int cyc;
    always @(posedge clk or negedge rst_n)
        if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

    int          fetch_n, wr_n, both_n, rst_wr_n;
    int          f_cyc [64];
    logic [31:0] f_adr [64];
    int          w_cyc [64];
    logic [31:0] w_adr [64];
    logic [31:0] w_dat [64];

    always @(negedge clk) begin
        if (!rst_n) begin
            fetch_n = 0; wr_n = 0; both_n = 0;
            if (mem_wr) rst_wr_n++;
        end else begin
            if (mem_rd && mem_wr) both_n++;
            if (mem_rd && mem_fetch && fetch_n < 64) begin
                f_cyc[fetch_n] = cyc; f_adr[fetch_n] = mem_addr; fetch_n++;
            end
            if (mem_wr && wr_n < 64) begin
                w_cyc[wr_n] = cyc; w_adr[wr_n] = mem_addr; w_dat[wr_n] = mem_wdata; wr_n++;
            end
        end
    end

    int errs = 0, checks = 0;
    bit done = 0;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_prog();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        for (int k = 0; k < 256; k++) mem[k] = 32'h0;
        for (int k = 0; k < NROW; k++) mem[PROG[k].addr[9:2]] = PROG[k].instr;
        mem[32'h200 >> 2] = 32'hCAFEF00D;
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int k = 0; k < 3000 && fetch_n < NROW + 1; k++) @(negedge clk);
        #1;
    endtask

    task automatic walk_table();
        int wi = 0;
        chk(rst_wr_n == 0, "R1", "write during reset", 32'(rst_wr_n), 0);
        chk(fetch_n >= NROW + 1, "R2", "fetch count", 32'(fetch_n), 32'(NROW + 1));
        if (fetch_n < NROW + 1) return;
        chk(f_cyc[0] == 0, "R1", "first fetch cycle", 32'(f_cyc[0]), 0);
        chk(f_adr[0] == 0, "R1", "first fetch addr", f_adr[0], 0);
        for (int i = 0; i < NROW; i++) begin
            row_t r = PROG[i];
            chk(f_adr[i] == r.addr, string'(r.tag), "fetch addr", f_adr[i], r.addr);
            chk(f_adr[i+1] == r.nxt, string'(r.tag), "next fetch addr", f_adr[i+1], r.nxt);
            chk(f_cyc[i+1] - f_cyc[i] == int'(r.cyc), string'(r.tag), "cycles",
                32'(f_cyc[i+1] - f_cyc[i]), 32'(r.cyc));
            if (r.wr) begin
                chk(w_adr[wi] == r.waddr, string'(r.tag), "store addr", w_adr[wi], r.waddr);
                chk(w_dat[wi] == r.wdata, string'(r.tag), "store data", w_dat[wi], r.wdata);
                chk(w_cyc[wi] == f_cyc[i] + 3, "R6", "store cycle",
                    32'(w_cyc[wi]), 32'(f_cyc[i] + 3));
                wi++;
            end
        end
        chk(wr_n == NWR, "R13", "total writes", 32'(wr_n), NWR);
        chk(both_n == 0, "R13", "read and write together", 32'(both_n), 0);
        chk(mem[32'h200 >> 2] == 32'h5, "R6", "memory after negative offset store",
            mem[32'h200 >> 2], 32'h5);
    endtask

    initial begin
        rst_wr_n = 0;
        run_prog();
        walk_table();
        // R1: reset applied while the program spins on its final jump, then a full rerun
        rst_wr_n = 0;
        run_prog();
        walk_table();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule